// File: doc/BRIEF.md
# Same-Bank Refresh Scheduler with Activation-Driven Refresh Management

This block decides when and where one DRAM rank, organised as bank groups, is refreshed one same-bank set at a time. A same-bank set is the group of banks that share one bank index across all bank groups. A free-running interval timer marks each refresh slot. On each slot the scheduler picks a set in which every bank is idle. If every set is busy, it postpones the slot, up to a bounded debt. When the debt reaches that bound, it forces the refresh and blocks the set's banks from taking new requests. After a refresh is taken it pulls further refreshes in, as long as unrefreshed sets of the current round are idle and the pulled-in credit is within its bound.

The same command slot also carries refresh-management requests driven by per-bank rolling activation counts. A bank whose count reaches the upper threshold triggers an immediate, blocking management refresh of its set. A bank whose count reaches only the lower threshold makes its set a candidate, and the candidate is served only when all of its banks are idle. A precharge of the set is requested first whenever any bank of the chosen set holds an open row.

Timing legality is judged elsewhere and arrives as a ready input. The owner of the activation counters clears a set's counters when it sees an accepted management refresh.

Top module: `rfsb_refresh_mgr`

## Requirements
- R1: After reset no command is requested (cmd_valid_o low, cmd_type_o 2'b00) and no bank is blocked.
- R2: With all banks idle and none open, the first refresh request (cmd_type_o 2'b10) appears T_REFSB cycles after reset release and targets set 0.
- R3: On a refresh slot, sets are searched in ascending order with wrap-around, starting after the last refreshed set. Any set that holds a non-idle bank is skipped. Bank b = g*BANKS_PER_GROUP + s belongs to set s.
- R4: If every set holds a non-idle bank on a slot and the debt is below MAX_POSTPONE*BANKS_PER_GROUP, no command is issued and the debt grows by one.
- R5: On a slot where the debt equals MAX_POSTPONE*BANKS_PER_GROUP, a refresh is requested for the set after the last refreshed one even if it is busy. All banks of that set have bank_block_o high until the command completes.
- R6: If any bank of the chosen set is open, a set precharge (2'b01) is requested first. Once it is accepted, the follow-up refresh or management refresh is requested for the same set, with the same blocking.
- R7: After an accepted refresh, further refreshes are pulled in back to back for idle sets not yet refreshed in the current round. This stops when the credit reaches MAX_PULLIN*BANKS_PER_GROUP or when no such set is idle. A round restarts once every set has been refreshed.
- R8: If RFM_EN is set and any bank's count (act_cnt_i[b*CNT_W +: CNT_W]) is at least RAA_MMT, a management refresh (2'b11) of the lowest such set is requested ahead of any refresh, with that set blocked.
- R9: A set with a bank count of at least RAA_IMT is served by a non-blocking management refresh only while all of its banks are idle.
- R10: A request is held with stable type and set until timing_ready_i and cmd_accept_i are both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_idle_i | input | NUM_GROUPS*BANKS_PER_GROUP | Bank has no request in progress |
| bank_active_i | input | NUM_GROUPS*BANKS_PER_GROUP | Bank has an open row |
| act_cnt_i | input | NUM_GROUPS*BANKS_PER_GROUP*CNT_W | Rolling activation count per bank |
| timing_ready_i | input | 1 | Timing constraints of the pending command are met |
| cmd_accept_i | input | 1 | Command slot taken by the issuer |
| cmd_valid_o | output | 1 | A command is requested |
| cmd_type_o | output | 2 | 00 none, 01 set precharge, 10 set refresh, 11 management refresh |
| cmd_set_o | output | clog2(BANKS_PER_GROUP) | Target same-bank set |
| bank_block_o | output | NUM_GROUPS*BANKS_PER_GROUP | Bank must not accept new requests |

## Verification
A wrong debt or credit count shows at the ports only at the next refresh slot. It appears there as a forced, blocked refresh that comes a slot too early or too late, or as a pull-in burst of the wrong length. Because of this, the directed scenarios run through several slots and count the commands issued. A wrong round mask or last-set pointer shows within one command as a wrong cmd_set_o. A lost follow-up after a set precharge shows on the very next cycle as a dropped or changed request.

// File: rtl/rfsb_pkg.sv
package rfsb_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_PRESB = 2'b01,
    CMD_REFSB = 2'b10,
    CMD_RFMSB = 2'b11
  } sb_cmd_e;

  typedef enum logic {
    MODE_REGULAR = 1'b0,
    MODE_PULLIN  = 1'b1
  } sb_mode_e;
endpackage

// File: rtl/rfsb_interval_timer.sv
module rfsb_interval_timer #(
  parameter int T_REFSB = 390
) (
  input  logic clk,
  input  logic rst_n,
  output logic due_o
);
  localparam int TW = $clog2(T_REFSB + 1);
  localparam logic [TW-1:0] RELOAD = TW'(T_REFSB);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    due_o = (cnt_q == TW'(1));
    cnt_d = due_o ? RELOAD : cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

  // R2: the slot counter stays inside its reload range
  a_r2_timer_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= TW'(1)) && (cnt_q <= RELOAD));
endmodule

// File: rtl/rfsb_set_status.sv
module rfsb_set_status #(
  parameter int NUM_GROUPS      = 4,
  parameter int BANKS_PER_GROUP = 4,
  parameter int CNT_W           = 8,
  parameter int RAA_IMT         = 32,
  parameter int RAA_MMT         = 96
) (
  input  logic [NUM_GROUPS*BANKS_PER_GROUP-1:0]       bank_idle_i,
  input  logic [NUM_GROUPS*BANKS_PER_GROUP-1:0]       bank_active_i,
  input  logic [NUM_GROUPS*BANKS_PER_GROUP*CNT_W-1:0] act_cnt_i,
  output logic [BANKS_PER_GROUP-1:0]                  set_busy_o,
  output logic [BANKS_PER_GROUP-1:0]                  set_open_o,
  output logic [BANKS_PER_GROUP-1:0]                  set_mmt_o,
  output logic [BANKS_PER_GROUP-1:0]                  set_imt_o
);
  localparam logic [CNT_W-1:0] LIM_HI = CNT_W'(RAA_MMT);
  localparam logic [CNT_W-1:0] LIM_LO = CNT_W'(RAA_IMT);

  for (genvar s = 0; s < BANKS_PER_GROUP; s++) begin : g_set
    always_comb begin
      set_busy_o[s] = 1'b0;
      set_open_o[s] = 1'b0;
      set_mmt_o[s]  = 1'b0;
      set_imt_o[s]  = 1'b0;
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (!bank_idle_i[g*BANKS_PER_GROUP+s])  set_busy_o[s] = 1'b1;
        if (bank_active_i[g*BANKS_PER_GROUP+s]) set_open_o[s] = 1'b1;
        if (act_cnt_i[(g*BANKS_PER_GROUP+s)*CNT_W +: CNT_W] >= LIM_HI) set_mmt_o[s] = 1'b1;
        if (act_cnt_i[(g*BANKS_PER_GROUP+s)*CNT_W +: CNT_W] >= LIM_LO) set_imt_o[s] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfsb_pick.sv
module rfsb_pick #(
  parameter int N  = 4,
  parameter int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  mask_i,
  input  logic [SW-1:0] start_i,
  output logic          found_o,
  output logic [SW-1:0] idx_o
);
  int p;

  // Search order: start_i+1, start_i+2, ... wrapping, start_i last
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    p       = 0;
    for (int k = 1; k <= N; k++) begin
      p = int'(start_i) + k;
      if (p >= N) p = p - N;
      if (!found_o && mask_i[p]) begin
        found_o = 1'b1;
        idx_o   = SW'(p);
      end
    end
  end
endmodule

// File: rtl/rfsb_refresh_mgr.sv
module rfsb_refresh_mgr #(
  parameter int   NUM_GROUPS      = 4,
  parameter int   BANKS_PER_GROUP = 4,
  parameter int   T_REFSB         = 390,
  parameter int   MAX_POSTPONE    = 2,
  parameter int   MAX_PULLIN      = 2,
  parameter int   CNT_W           = 8,
  parameter int   RAA_IMT         = 32,
  parameter int   RAA_MMT         = 96,
  parameter bit   RFM_EN          = 1'b1,
  parameter int   NB              = NUM_GROUPS * BANKS_PER_GROUP,
  parameter int   SET_W           = (BANKS_PER_GROUP > 1) ? $clog2(BANKS_PER_GROUP) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NB-1:0]         bank_idle_i,
  input  logic [NB-1:0]         bank_active_i,
  input  logic [NB*CNT_W-1:0]   act_cnt_i,
  input  logic                  timing_ready_i,
  input  logic                  cmd_accept_i,
  output logic                  cmd_valid_o,
  output logic [1:0]            cmd_type_o,
  output logic [SET_W-1:0]      cmd_set_o,
  output logic [NB-1:0]         bank_block_o
);
  import rfsb_pkg::*;

  localparam int POST_LIM = MAX_POSTPONE * BANKS_PER_GROUP;
  localparam int PULL_LIM = MAX_PULLIN * BANKS_PER_GROUP;
  localparam int FLEX_W   = $clog2(POST_LIM + PULL_LIM + 2) + 2;
  localparam logic signed [FLEX_W-1:0] FLEX_POST = FLEX_W'(POST_LIM);
  localparam logic signed [FLEX_W-1:0] FLEX_PULL = -FLEX_W'(PULL_LIM);
  localparam logic signed [FLEX_W-1:0] FLEX_ONE  = FLEX_W'(1);
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(BANKS_PER_GROUP - 1);

  // ---------------- status, timer, pickers ----------------
  logic [BANKS_PER_GROUP-1:0] set_busy, set_open, set_mmt, set_imt;
  logic due;

  rfsb_set_status #(
    .NUM_GROUPS(NUM_GROUPS), .BANKS_PER_GROUP(BANKS_PER_GROUP),
    .CNT_W(CNT_W), .RAA_IMT(RAA_IMT), .RAA_MMT(RAA_MMT)
  ) u_status (
    .bank_idle_i(bank_idle_i), .bank_active_i(bank_active_i), .act_cnt_i(act_cnt_i),
    .set_busy_o(set_busy), .set_open_o(set_open), .set_mmt_o(set_mmt), .set_imt_o(set_imt)
  );

  rfsb_interval_timer #(.T_REFSB(T_REFSB)) u_timer (
    .clk(clk), .rst_n(rst_n), .due_o(due)
  );

  // registered state
  sb_mode_e                   mode_q, mode_d;
  logic signed [FLEX_W-1:0]   flex_q, flex_d;
  logic                       due_pend_q, due_pend_d;
  logic                       pend_v_q, pend_v_d;
  logic                       pend_pre_q, pend_pre_d;
  logic                       pend_rfm_q, pend_rfm_d;
  logic                       pend_blk_q, pend_blk_d;
  logic [SET_W-1:0]           pend_set_q, pend_set_d;
  logic [SET_W-1:0]           last_set_q, last_set_d;
  logic [BANKS_PER_GROUP-1:0] done_q, done_d;

  logic             reg_found, pull_found, mmt_found, cand_found;
  logic [SET_W-1:0] reg_idx, pull_idx, mmt_idx, cand_idx;

  rfsb_pick #(.N(BANKS_PER_GROUP), .SW(SET_W)) u_pick_reg (
    .mask_i(~set_busy), .start_i(last_set_q), .found_o(reg_found), .idx_o(reg_idx));
  rfsb_pick #(.N(BANKS_PER_GROUP), .SW(SET_W)) u_pick_pull (
    .mask_i(~set_busy & ~done_q), .start_i(last_set_q), .found_o(pull_found), .idx_o(pull_idx));
  rfsb_pick #(.N(BANKS_PER_GROUP), .SW(SET_W)) u_pick_mmt (
    .mask_i(set_mmt), .start_i(LAST_SET), .found_o(mmt_found), .idx_o(mmt_idx));
  rfsb_pick #(.N(BANKS_PER_GROUP), .SW(SET_W)) u_pick_cand (
    .mask_i(set_imt & ~set_busy), .start_i(LAST_SET), .found_o(cand_found), .idx_o(cand_idx));

  // ---------------- next state ----------------
  logic                       fire, due_any, forced;
  logic signed [FLEX_W-1:0]   flex_dec;
  logic [BANKS_PER_GROUP-1:0] done_upd;
  logic [SET_W-1:0]           next_set;

  always_comb begin
    fire     = pend_v_q & timing_ready_i & cmd_accept_i;
    due_any  = due | due_pend_q;
    forced   = (flex_q == FLEX_POST);
    flex_dec = flex_q - FLEX_ONE;
    done_upd = done_q | (BANKS_PER_GROUP'(1) << pend_set_q);
    next_set = (last_set_q == LAST_SET) ? '0 : last_set_q + SET_W'(1);

    mode_d     = mode_q;
    flex_d     = flex_q;
    due_pend_d = due_pend_q | due;
    pend_v_d   = pend_v_q;
    pend_pre_d = pend_pre_q;
    pend_rfm_d = pend_rfm_q;
    pend_blk_d = pend_blk_q;
    pend_set_d = pend_set_q;
    last_set_d = last_set_q;
    done_d     = done_q;

    // a slot arriving during pull-in ends the pull-in burst
    if (due && mode_q == MODE_PULLIN) mode_d = MODE_REGULAR;

    if (pend_v_q) begin
      if (fire) begin
        if (pend_pre_q) begin
          pend_pre_d = 1'b0;
        end else begin
          pend_v_d   = 1'b0;
          pend_blk_d = 1'b0;
          if (!pend_rfm_q) begin
            flex_d     = flex_dec;
            last_set_d = pend_set_q;
            done_d     = (&done_upd) ? '0 : done_upd;
            mode_d     = (flex_dec > FLEX_PULL && !due_any) ? MODE_PULLIN : MODE_REGULAR;
          end
        end
      end
    end else if (RFM_EN && mmt_found) begin
      pend_v_d   = 1'b1;
      pend_rfm_d = 1'b1;
      pend_blk_d = 1'b1;
      pend_set_d = mmt_idx;
      pend_pre_d = set_open[mmt_idx];
    end else if (mode_q == MODE_REGULAR && due_any) begin
      due_pend_d = 1'b0;
      flex_d     = flex_q + FLEX_ONE;
      if (reg_found || forced) begin
        pend_v_d   = 1'b1;
        pend_rfm_d = 1'b0;
        pend_blk_d = !reg_found;
        pend_set_d = reg_found ? reg_idx : next_set;
        pend_pre_d = set_open[reg_found ? reg_idx : next_set];
      end
    end else if (mode_q == MODE_PULLIN) begin
      if (pull_found) begin
        pend_v_d   = 1'b1;
        pend_rfm_d = 1'b0;
        pend_blk_d = 1'b0;
        pend_set_d = pull_idx;
        pend_pre_d = set_open[pull_idx];
      end else begin
        mode_d = MODE_REGULAR;
      end
    end else if (RFM_EN && cand_found) begin
      pend_v_d   = 1'b1;
      pend_rfm_d = 1'b1;
      pend_blk_d = 1'b0;
      pend_set_d = cand_idx;
      pend_pre_d = set_open[cand_idx];
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_REGULAR;
      flex_q     <= '0;
      due_pend_q <= 1'b0;
      pend_v_q   <= 1'b0;
      pend_pre_q <= 1'b0;
      pend_rfm_q <= 1'b0;
      pend_blk_q <= 1'b0;
      pend_set_q <= '0;
      last_set_q <= LAST_SET;
      done_q     <= '0;
    end else begin
      mode_q     <= mode_d;
      flex_q     <= flex_d;
      due_pend_q <= due_pend_d;
      pend_v_q   <= pend_v_d;
      pend_pre_q <= pend_pre_d;
      pend_rfm_q <= pend_rfm_d;
      pend_blk_q <= pend_blk_d;
      pend_set_q <= pend_set_d;
      last_set_q <= last_set_d;
      done_q     <= done_d;
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    cmd_valid_o = pend_v_q;
    cmd_set_o   = pend_set_q;
    if (!pend_v_q)      cmd_type_o = CMD_NONE;
    else if (pend_pre_q) cmd_type_o = CMD_PRESB;
    else if (pend_rfm_q) cmd_type_o = CMD_RFMSB;
    else                 cmd_type_o = CMD_REFSB;
  end

  for (genvar b = 0; b < NB; b++) begin : g_blk
    assign bank_block_o[b] = pend_v_q & pend_blk_q & (pend_set_q == SET_W'(b % BANKS_PER_GROUP));
  end

  // ---------------- assertions ----------------
  // R10: a request not taken stays unchanged
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !(timing_ready_i && cmd_accept_i)) |=>
      (cmd_valid_o && $stable(cmd_type_o) && $stable(cmd_set_o)));

  // R6: an accepted set precharge is followed by its refresh on the same set
  a_r6_pre_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_type_o == CMD_PRESB && timing_ready_i && cmd_accept_i) |=>
      (cmd_valid_o && cmd_type_o != CMD_PRESB && $stable(cmd_set_o) && $stable(bank_block_o)));

  // R5, R8: blocking only accompanies a request
  a_r5_block_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_block_o) |-> cmd_valid_o);

  // R4: postpone debt and pull-in credit stay within their bounds
  a_r4_flex_range: assert property (@(posedge clk) disable iff (!rst_n)
    (flex_q >= FLEX_PULL) && (flex_q <= FLEX_POST + FLEX_ONE));

  // R7: pull-in never starts once the credit bound is reached
  a_r7_pullin_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PULLIN) |-> (flex_q > FLEX_PULL));
endmodule

// File: tb/rfsb_refresh_mgr_tb_top.sv
`timescale 1ns/1ps
module rfsb_refresh_mgr_tb_top;
  localparam int NG = 2, BPG = 4, NB = NG * BPG, T = 32, CW = 6;

  logic clk, rst_n;
  logic [NB-1:0]    idle, active, blk;
  logic [NB*CW-1:0] cnt;
  logic             rdy, acc, vld;
  logic [1:0]       typ;
  logic [1:0]       setx;

  rfsb_refresh_mgr #(
    .NUM_GROUPS(NG), .BANKS_PER_GROUP(BPG), .T_REFSB(T), .MAX_POSTPONE(1),
    .MAX_PULLIN(1), .CNT_W(CW), .RAA_IMT(8), .RAA_MMT(16), .RFM_EN(1'b1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bank_idle_i(idle), .bank_active_i(active),
    .act_cnt_i(cnt), .timing_ready_i(rdy), .cmd_accept_i(acc),
    .cmd_valid_o(vld), .cmd_type_o(typ), .cmd_set_o(setx), .bank_block_o(blk)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, nlog = 0;
  bit finished = 0;
  logic [1:0]    lt [64];
  logic [1:0]    ls [64];
  logic [NB-1:0] lb [64];

  // log every command taken at a clock edge
  always @(posedge clk)
    if (rst_n && vld && rdy && acc && nlog < 64) begin
      lt[nlog] = typ; ls[nlog] = setx; lb[nlog] = blk; nlog = nlog + 1;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [NB-1:0] idl, input logic [NB-1:0] act);
    rst_n = 1'b0; idle = idl; active = act; cnt = '0; rdy = 1'b1; acc = 1'b1;
    repeat (3) @(negedge clk);
    nlog = 0;
    rst_n = 1'b1;
  endtask

  task automatic set_cnt(input int b, input int v);
    cnt[b*CW +: CW] = CW'(v);
  endtask

  // R1, R2, R7: first slot then a pull-in burst over one round
  task automatic t_periodic_pullin();
    do_reset('1, '0);
    @(negedge clk);
    chk(!vld && typ == 2'b00 && blk == '0, "R1 reset idle", int'(vld), 0);
    repeat (T - 2) @(negedge clk);
    chk(!vld, "R2 no request before slot", int'(vld), 0);
    @(negedge clk);
    chk(vld && typ == 2'b10, "R2 refresh at slot", int'(typ), 2);
    chk(setx == 2'd0, "R2 first set", int'(setx), 0);
    repeat (14) @(negedge clk);
    chk(nlog == 5, "R7 pull-in burst length", nlog, 5);
    for (int i = 0; i < 5 && i < nlog; i++) begin
      chk(ls[i] == 2'(i % 4) && lt[i] == 2'b10, "R7 pull-in order", int'(ls[i]), i % 4);
    end
    repeat (T + 4) @(negedge clk);
    chk(nlog == 6, "R7 one refresh per slot at credit bound", nlog, 6);
    if (nlog >= 6) chk(ls[5] == 2'd1, "R3 next set after last", int'(ls[5]), 1);
  endtask

  // R3: busy sets are skipped
  task automatic t_opportunistic();
    do_reset(8'b1110_1101, '0);
    repeat (T + 20) @(negedge clk);
    chk(nlog == 2, "R3 idle sets only", nlog, 2);
    if (nlog >= 2) begin
      chk(ls[0] == 2'd2, "R3 first idle set", int'(ls[0]), 2);
      chk(ls[1] == 2'd3, "R3 pulled-in idle set", int'(ls[1]), 3);
    end
  endtask

  // R4, R5, R6: postpone to the bound, then forced and blocked
  task automatic t_postpone_forced();
    do_reset('0, 8'b0001_0000);
    rdy = 1'b0;
    repeat (5 * T - 2) @(negedge clk);
    chk(!vld && nlog == 0, "R4 busy slots postponed", nlog, 0);
    repeat (2) @(negedge clk);
    chk(vld && typ == 2'b01, "R6 precharge first", int'(typ), 1);
    chk(setx == 2'd0, "R5 forced set", int'(setx), 0);
    chk(blk == 8'h11, "R5 forced blocks set", int'(blk), 'h11);
    rdy = 1'b1;
    @(negedge clk);
    chk(vld && typ == 2'b10 && setx == 2'd0, "R6 refresh follows", int'(typ), 2);
    chk(blk == 8'h11, "R6 block kept", int'(blk), 'h11);
    @(negedge clk);
    chk(nlog == 2 && blk == '0, "R5 block released", int'(blk), 0);
  endtask

  // R8, R10: threshold-driven management refresh
  task automatic t_rfm_max();
    do_reset('1, 8'b0000_0100);
    set_cnt(6, 16); set_cnt(3, 20);
    rdy = 1'b0;
    @(negedge clk);
    chk(vld && typ == 2'b01 && setx == 2'd2, "R8 lowest set, precharge", int'(setx), 2);
    chk(blk == 8'h44, "R8 set blocked", int'(blk), 'h44);
    @(negedge clk);
    chk(vld && typ == 2'b01 && setx == 2'd2, "R10 held without ready", int'(typ), 1);
    rdy = 1'b1; acc = 1'b0;
    @(negedge clk);
    chk(vld && typ == 2'b01 && nlog == 0, "R10 held without accept", nlog, 0);
    acc = 1'b1;
    @(negedge clk);
    chk(vld && typ == 2'b11 && setx == 2'd2, "R8 management refresh", int'(typ), 3);
    set_cnt(6, 0);
    repeat (2) @(negedge clk);
    chk(vld && typ == 2'b11 && setx == 2'd3 && blk == 8'h88, "R8 next set", int'(setx), 3);
    set_cnt(3, 0);
  endtask

  // R9: candidate served only when its set is idle
  task automatic t_rfm_cand();
    do_reset(8'b1111_0111, '0);
    set_cnt(7, 10);
    repeat (10) @(negedge clk);
    chk(!vld && nlog == 0, "R9 busy candidate waits", nlog, 0);
    idle = '1;
    for (int i = 0; i < 8 && nlog == 0; i++) @(negedge clk);
    set_cnt(7, 0);
    chk(nlog == 1, "R9 candidate served", nlog, 1);
    if (nlog >= 1) begin
      chk(lt[0] == 2'b11 && ls[0] == 2'd3, "R9 type and set", int'(ls[0]), 3);
      chk(lb[0] == '0, "R9 no blocking", int'(lb[0]), 0);
    end
    repeat (4) @(negedge clk);
    chk(nlog == 1, "R9 single service", nlog, 1);
  endtask

  initial begin
    t_periodic_pullin();
    t_opportunistic();
    t_postpone_forced();
    t_rfm_max();
    t_rfm_cand();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule